// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a small single-cycle register bus. A shared control word carries a run bit and an auto-reload bit for each counter. Every enabled counter drops by one on each clock. When a counter sits at zero and is clocked again, it expires. In auto-reload mode it then takes its reload value. In one-shot mode it stays at zero and clears its own run bit.

Each expiry latches a cause bit. A mask bit per timer decides whether that latched cause drives the timer's interrupt line. Software acknowledges a cause by writing a zero into its bit position. Software can read the live count at any time; bit-inverting it gives an up-counting time base.

Top module: `dual_dcount_timer`

## Requirements
- R1: After reset, the control, mask and cause registers read zero, both counters read zero and both interrupt lines are low.
- R2: Control register at offset 0x00: bit 0 is the run bit of timer 0, bit 1 its auto-reload bit, bit 2 the run bit of timer 1, bit 3 its auto-reload bit. A running counter above zero decreases by exactly one per clock, and the two counters run independently.
- R3: Clearing a run bit freezes that counter at its current value. The write cycle itself still counts once.
- R4: A running counter with auto-reload set that is clocked at zero takes its reload value and expires. Loading N-1 into both the reload and the value register therefore gives an expiry every N clocks.
- R5: A running counter with auto-reload clear that is clocked at zero expires, stays at zero and clears its own run bit in the control register.
- R6: Writing the value register takes effect at that clock edge and overrides decrement and expiry, even while the counter runs. Any 32-bit value, including 0xFFFFFFFE, is accepted.
- R7: Cause register at offset 0x110 and mask register at 0x114. Bit 1 belongs to timer 0 and bit 2 to timer 1. An expiry sets the timer's cause bit on the same edge.
- R8: A timer's interrupt output is high exactly when its cause bit and mask bit are both set. Clearing the mask bit drops the output but leaves the cause bit set.
- R9: Cause bits are cleared by writing 0 to them. Writing 1 leaves the bit unchanged.
- R10: An expiry in the same cycle as a write that clears that cause bit leaves the bit set.
- R11: A one-shot counter started at zero expires on the next clock and then stops.
- R12: Reload registers at 0x10 (timer 0) and 0x18 (timer 1) and value registers at 0x14 and 0x1C read back their contents. Unused control and mask bits, and unmapped offsets, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge is one count tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tmr_irq | output | 2 | Interrupt line per timer; bit 0 is timer 0 |

## Verification
Two things can land on the same cause bit in one cycle: a counter expiry and a software write that clears the bit. The bench starts a one-shot count of known length. It times the clearing write so that its edge is the expiry edge, and then expects the bit still set. A second coincidence is a value write on a running counter. The bench judges it by the count read one and two edges later, which must follow the new value and not the old decrement.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int NUM_TMR = 2;

    localparam int OFF_CTRL   = 'h000;
    localparam int OFF_RLD0   = 'h010;
    localparam int OFF_VAL0   = 'h014;
    localparam int TMR_STRIDE = 'h008;
    localparam int OFF_CAUSE  = 'h110;
    localparam int OFF_MASK   = 'h114;

    // cause/mask bit of timer i sits at position i + CAUSE_LSB
    localparam int CAUSE_LSB = 1;

    typedef struct packed {
        logic autoload;
        logic run;
    } tmr_ctl_t;

    function automatic int rld_off(input int idx);
        return OFF_RLD0 + idx * TMR_STRIDE;
    endfunction

    function automatic int val_off(input int idx);
        return OFF_VAL0 + idx * TMR_STRIDE;
    endfunction

endpackage

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             autoload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = run && at_zero && !load_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_we) begin
            count <= load_val;
        end else if (run) begin
            if (!at_zero) begin
                count <= count - 1'b1;
            end else if (autoload) begin
                count <= reload_val;
            end
        end
    end

    // R2: one step down per clock while running above zero
    p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !load_we && !at_zero) |=> (count == $past(count) - 1'b1));

    // R3: a stopped counter holds
    p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_we) |=> $stable(count));

    // R4: expiry with auto-reload takes the reload value
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (expire && autoload) |=> (count == $past(reload_val)));

    // R6: a value write lands on the next edge
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        load_we |=> (count == $past(load_val)));

endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         cause_we,
    input  logic [N-1:0] cause_keep,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wval,
    output logic [N-1:0] cause,
    output logic [N-1:0] mask,
    output logic [N-1:0] irq
);

    logic [N-1:0] keep_bits;

    assign keep_bits = cause_we ? cause_keep : {N{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= '0;
            mask  <= '0;
        end else begin
            cause <= (cause & keep_bits) | set;
            if (mask_we) begin
                mask <= mask_wval;
            end
        end
    end

    assign irq = cause & mask;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10: a new event beats a simultaneous clear
        p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> cause[i]);

        // R9: writing zero clears when nothing new arrives
        p_zero_clears_r9: assert property (@(posedge clk) disable iff (rst)
            (cause_we && !cause_keep[i] && !set[i]) |=> !cause[i]);

        // R8: a pending cause survives everything except a clearing write
        p_cause_holds_r8: assert property (@(posedge clk) disable iff (rst)
            (cause[i] && !(cause_we && !cause_keep[i])) |=> cause[i]);
    end

endmodule

// File: rtl/dual_dcount_timer.sv
module dual_dcount_timer
    import dtmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TMR-1:0] tmr_irq
);

    localparam int BIT_HI = CAUSE_LSB + NUM_TMR - 1;

    logic                      wr;
    logic                      ctrl_we;
    logic                      cause_we;
    logic                      mask_we;
    tmr_ctl_t [NUM_TMR-1:0]    ctl_q;
    logic [NUM_TMR-1:0]        val_we;
    logic [NUM_TMR-1:0]        rld_we;
    logic [NUM_TMR-1:0]        expire;
    logic [DATA_W-1:0]         rld_q [NUM_TMR];
    logic [DATA_W-1:0]         count [NUM_TMR];
    logic [NUM_TMR-1:0]        cause;
    logic [NUM_TMR-1:0]        mask;

    assign wr       = bus_sel && bus_we;
    assign ctrl_we  = wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign cause_we = wr && (bus_addr == ADDR_W'(OFF_CAUSE));
    assign mask_we  = wr && (bus_addr == ADDR_W'(OFF_MASK));

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        assign rld_we[i] = wr && (bus_addr == ADDR_W'(rld_off(i)));
        assign val_we[i] = wr && (bus_addr == ADDR_W'(val_off(i)));

        always_ff @(posedge clk) begin
            if (rst) begin
                rld_q[i] <= '0;
            end else if (rld_we[i]) begin
                rld_q[i] <= bus_wdata;
            end
        end

        // a control write wins; otherwise a one-shot expiry stops the timer
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[i] <= '0;
            end else if (ctrl_we) begin
                ctl_q[i].run      <= bus_wdata[2*i];
                ctl_q[i].autoload <= bus_wdata[2*i+1];
            end else if (expire[i] && !ctl_q[i].autoload) begin
                ctl_q[i].run <= 1'b0;
            end
        end

        dtmr_counter #(
            .CNT_W (DATA_W)
        ) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .run        (ctl_q[i].run),
            .autoload   (ctl_q[i].autoload),
            .reload_val (rld_q[i]),
            .load_we    (val_we[i]),
            .load_val   (bus_wdata),
            .count      (count[i]),
            .expire     (expire[i])
        );

        // R5: one-shot expiry clears the run bit
        p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (rst)
            (expire[i] && !ctl_q[i].autoload && !ctrl_we) |=> !ctl_q[i].run);

        // R7: expiry is reported in the cause bit
        p_expiry_cause_r7: assert property (@(posedge clk) disable iff (rst)
            expire[i] |=> cause[i]);
    end

    dtmr_irq #(
        .N (NUM_TMR)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .set        (expire),
        .cause_we   (cause_we),
        .cause_keep (bus_wdata[BIT_HI:CAUSE_LSB]),
        .mask_we    (mask_we),
        .mask_wval  (bus_wdata[BIT_HI:CAUSE_LSB]),
        .cause      (cause),
        .mask       (mask),
        .irq        (tmr_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                bus_rdata[2*i]   = ctl_q[i].run;
                bus_rdata[2*i+1] = ctl_q[i].autoload;
            end
        end else if (bus_addr == ADDR_W'(OFF_CAUSE)) begin
            bus_rdata[BIT_HI:CAUSE_LSB] = cause;
        end else if (bus_addr == ADDR_W'(OFF_MASK)) begin
            bus_rdata[BIT_HI:CAUSE_LSB] = mask;
        end else begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (bus_addr == ADDR_W'(rld_off(i))) bus_rdata = rld_q[i];
                if (bus_addr == ADDR_W'(val_off(i))) bus_rdata = count[i];
            end
        end
    end

    // R8: a masked-off timer never interrupts
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !mask[0] |-> !tmr_irq[0]);

endmodule

// File: tb/sim_dual_dcount_timer.sv
module sim_dual_dcount_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  tmr_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dual_dcount_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq)
    );

    localparam logic [11:0] A_CTRL = 12'h000, A_RLD0 = 12'h010, A_VAL0 = 12'h014,
                            A_RLD1 = 12'h018, A_VAL1 = 12'h01C,
                            A_CAUSE = 12'h110, A_MASK = 12'h114;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk_rd("R1 ctrl", A_CTRL, 0);
        chk_rd("R1 cause", A_CAUSE, 0);
        chk_rd("R1 mask", A_MASK, 0);
        chk_rd("R1 val0", A_VAL0, 0);
        chk_rd("R1 val1", A_VAL1, 0);
        chk("R1 irq", {30'd0, tmr_irq}, 0);
    endtask

    task automatic t_count_and_freeze;
        wr(A_VAL0, 100);
        wr(A_CTRL, 32'h1);
        chk_rd("R2 start", A_VAL0, 100);
        tick(7);
        chk_rd("R2 decrement", A_VAL0, 93);
        chk_rd("R2 other timer idle", A_VAL1, 0);
        wr(A_CTRL, 32'h0);
        chk_rd("R3 stop edge counts", A_VAL0, 92);
        tick(5);
        chk_rd("R3 frozen", A_VAL0, 92);
    endtask

    task automatic t_periodic;
        wr(A_MASK, 32'h2);
        wr(A_RLD0, 4);
        wr(A_VAL0, 4);
        wr(A_CTRL, 32'h3);
        tick(4);
        chk_rd("R4 at zero", A_VAL0, 0);
        chk_rd("R4 no cause yet", A_CAUSE, 0);
        tick(1);
        chk_rd("R4 reloaded", A_VAL0, 4);
        chk_rd("R7 cause bit1", A_CAUSE, 32'h2);
        chk("R8 irq0 high", {31'd0, tmr_irq[0]}, 1);
        wr(A_CAUSE, 32'hFFFF_FFFD);
        chk_rd("R9 cleared", A_CAUSE, 0);
        tick(3);
        chk_rd("R4 period no early", A_CAUSE, 0);
        tick(1);
        chk_rd("R4 period of 5", A_CAUSE, 32'h2);
        wr(A_MASK, 32'h0);
        chk("R8 masked irq low", {31'd0, tmr_irq[0]}, 0);
        chk_rd("R8 cause kept", A_CAUSE, 32'h2);
        wr(A_MASK, 32'h2);
        chk("R8 unmask irq", {31'd0, tmr_irq[0]}, 1);
        wr(A_CTRL, 32'h0);
        wr(A_CAUSE, 32'h0);
        chk_rd("R9 all clear", A_CAUSE, 0);
    endtask

    task automatic t_oneshot;
        wr(A_MASK, 32'h4);
        wr(A_VAL1, 3);
        wr(A_CTRL, 32'h4);
        tick(3);
        chk_rd("R5 at zero", A_VAL1, 0);
        chk_rd("R5 no cause yet", A_CAUSE, 0);
        tick(1);
        chk_rd("R5 cause bit2", A_CAUSE, 32'h4);
        chk_rd("R5 run cleared", A_CTRL, 0);
        chk("R8 irq1 high", {31'd0, tmr_irq[1]}, 1);
        tick(5);
        chk_rd("R5 stays zero", A_VAL1, 0);
        wr(A_CAUSE, 32'hFFFF_FFFF);
        chk_rd("R9 ones keep", A_CAUSE, 32'h4);
        wr(A_CAUSE, 32'hFFFF_FFFB);
        chk_rd("R9 zero clears", A_CAUSE, 0);
        chk("R8 irq1 low", {31'd0, tmr_irq[1]}, 0);
    endtask

    task automatic t_zero_oneshot;
        wr(A_CTRL, 32'h4);
        chk_rd("R11 armed", A_CTRL, 32'h4);
        tick(1);
        chk_rd("R11 fired", A_CAUSE, 32'h4);
        chk_rd("R11 stopped", A_CTRL, 0);
        wr(A_CAUSE, 32'h0);
    endtask

    task automatic t_set_wins;
        wr(A_VAL1, 2);
        wr(A_CTRL, 32'h4);
        tick(2);
        chk_rd("R10 at zero", A_VAL1, 0);
        wr(A_CAUSE, 32'h0);
        chk_rd("R10 set beats clear", A_CAUSE, 32'h4);
        wr(A_CAUSE, 32'h0);
    endtask

    task automatic t_live_load;
        wr(A_VAL0, 50);
        wr(A_CTRL, 32'h1);
        tick(3);
        wr(A_VAL0, 7);
        chk_rd("R6 new value", A_VAL0, 7);
        tick(1);
        chk_rd("R6 counts from new", A_VAL0, 6);
        wr(A_VAL0, 32'hFFFF_FFFE);
        tick(1);
        chk_rd("R6 large load", A_VAL0, 32'hFFFF_FFFD);
        wr(A_VAL0, 0);
        chk_rd("R6 load beats expiry", A_CAUSE, 0);
        wr(A_CTRL, 32'h0);
        wr(A_CAUSE, 32'h0);
    endtask

    task automatic t_readback;
        wr(A_RLD0, 32'h1234_5678);
        wr(A_RLD1, 32'hCAFE_0001);
        chk_rd("R12 reload0", A_RLD0, 32'h1234_5678);
        chk_rd("R12 reload1", A_RLD1, 32'hCAFE_0001);
        wr(A_MASK, 32'hFFFF_FFFF);
        chk_rd("R12 mask bits", A_MASK, 32'h6);
        wr(A_CTRL, 32'hFFFF_FFF0);
        chk_rd("R12 ctrl bits", A_CTRL, 0);
        chk_rd("R12 unmapped", 12'h020, 0);
    endtask

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_count_and_freeze();
        t_periodic();
        t_oneshot();
        t_zero_oneshot();
        t_set_wins();
        t_live_load();
        t_readback();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule